// File: doc/BRIEF.md
# Register-Programmed Two-Bus I2C Master

This block runs single I2C transactions on behalf of software. Software writes a settings word with the clock divider, the bus choice and an enable bit. It then writes a command word that carries the target's 7-bit address, the direction, an optional 16-bit read flag, a data byte and an execute bit. The controller drives the chosen bus through open-drain enables and carries out the transaction. When it finishes, it posts a two-bit completion code and up to two received bytes in a reply word.

The bit engine splits every SCL period into four equal quarters. The quarter length is one fourth of the programmed divider, counted in system clocks. Data on SDA moves only while SCL is held low. The start and stop conditions are the only exceptions. A bad acknowledge from the target ends the transaction as a failure, and a stop condition is still sent on the bus.

Register map, by word offset on the register port: 0 is settings, 1 is command, 2 is reply. Offset 3 reads as zero. An output enable of 1 pulls the line low. An enable of 0 releases the line.

Top module: `i2c_reg_master`

## Requirements
- R1: The divider is settings bits [9:0], called P, with P of at least 4. Each SCL quarter lasts P/4 clocks, so SCL stays released for P/2 consecutive clocks in every bit. Settings bits [12:0] read back as written, and bits [31:13] read as 0.
- R2: Settings bit 10 picks bus 1 when it is 1 and bus 0 when it is 0. The bit is captured when a transaction is accepted. The other bus keeps both of its enables at 0.
- R3: Settings bit 11 enables the controller. A command whose execute bit is set while bit 11 is 0 is ignored: the bus does nothing and the reply word does not change.
- R4: The command fields are: bits [7:0] the write byte, bits [22:16] the address, bit 23 the direction (1 for write, 0 for read), bit 25 the 16-bit read flag, and bit 31 execute. Execute clears itself, so the command word reads back with bit 31 at 0 and bits [30:0] as written.
- R5: The reply status sits in bits [27:26]. It reads 00 (pending) from the clock after a transaction is accepted until the transaction is over. It then reads 01 for success or 11 for failure. The reset value of the whole reply word is 0.
- R6: A write sends a start, then the byte {address, 0}, then the write byte, then a stop.
- R7: A read with bit 25 at 0 sends {address, 1}, receives one byte into reply bits [7:0], and answers that byte with a NACK before the stop. Reply bits [15:8] read 0.
- R8: A read with bit 25 at 1 receives two bytes. The master ACKs the first and NACKs the second. The first byte goes to reply bits [15:8] and the second to bits [7:0].
- R9: A missing acknowledge on the address byte or on the write byte gives status 11, and the stop is still sent.
- R10: While SCL stays released, SDA changes only to make a start (falling edge) or a stop (rising edge). Both lines are released whenever no transaction is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| sda_i | input | 2 | SDA line level for each bus |
| scl_oe_o | output | 2 | SCL pull-low enable for each bus |
| sda_oe_o | output | 2 | SDA pull-low enable for each bus |

## Verification
Some properties hold on every cycle, and the assertions watch these:
- only one bus is ever driven;
- both lines are released when the controller is idle;
- SDA moves under a released SCL only for a start or a stop;
- a disabled controller never starts;
- the status reads pending for the whole transaction and ends as success or failure.

Other behaviour shows only through the bench's scenarios, which run against a bench-side I2C target. These are the bytes that reach the target, the ACK/NACK pattern on reads, and where the two bytes land in 16-bit mode. They also include the SCL high time and the failure paths for a wrong address and for a refused data byte.

// File: rtl/i2c_ctl_pkg.sv
`timescale 1ns/1ps
package i2c_ctl_pkg;
  localparam int REG_W       = 32;
  localparam int NBUS        = 2;
  localparam int SET_BUS_BIT = 10;
  localparam int SET_EN_BIT  = 11;
  localparam int SET_W       = 13;
  localparam int CMD_WR_BIT  = 23;
  localparam int CMD_M16_BIT = 25;
  localparam int CMD_GO_BIT  = 31;

  localparam logic [1:0] STAT_PEND = 2'b00;
  localparam logic [1:0] STAT_OK   = 2'b01;
  localparam logic [1:0] STAT_FAIL = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} seq_st_e;
  typedef enum logic [1:0] {SL_ADDR, SL_WR, SL_RD1, SL_RD2} slot_e;

  typedef struct packed {
    logic [6:0] addr;
    logic       wr;
    logic       m16;
    logic [7:0] wbyte;
  } xfer_t;
endpackage

// File: rtl/i2c_quarter_div.sv
`timescale 1ns/1ps
module i2c_quarter_div #(
  parameter int PRESC_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               load_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int QW = PRESC_W - 2;

  logic [QW-1:0] quarter, cnt_q;

  assign quarter = (presc_i[PRESC_W-1:2] == '0) ? QW'(1) : presc_i[PRESC_W-1:2];
  assign tick_o  = run_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i || tick_o)        cnt_q <= quarter - QW'(1);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - QW'(1);
  end
endmodule

// File: rtl/i2c_bus_mux.sv
`timescale 1ns/1ps
module i2c_bus_mux #(
  parameter int NBUS = 2,
  localparam int SELW = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SELW-1:0] sel_i,
  input  logic            scl_low_i,
  input  logic            sda_low_i,
  input  logic [NBUS-1:0] sda_i,
  output logic [NBUS-1:0] scl_oe_o,
  output logic [NBUS-1:0] sda_oe_o,
  output logic            sda_o
);
  logic [NBUS-1:0] sync1_q, sync2_q;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign scl_oe_o[b] = scl_low_i && (sel_i == SELW'(b));
    assign sda_oe_o[b] = sda_low_i && (sel_i == SELW'(b));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= sda_i;
      sync2_q <= sync1_q;
    end
  end

  assign sda_o = sync2_q[sel_i];
endmodule

// File: rtl/i2c_bit_seq.sv
`timescale 1ns/1ps
module i2c_bit_seq
  import i2c_ctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        go_i,
  input  xfer_t       xfer_i,
  input  logic        sda_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [15:0] rdata_o,
  output logic        scl_low_o,
  output logic        sda_low_o,
  output seq_st_e     st_o
);
  seq_st_e     st_q;
  slot_e       slot_q;
  xfer_t       x_q;
  logic [1:0]  ph_q;
  logic [3:0]  bit_q;
  logic        sda_q, samp_q, fail_q, done_q;
  logic [15:0] rx_q;
  logic        drv_bit;     // 1 = release
  logic [2:0]  idx;
  logic [7:0]  addr_byte;
  logic        last_bit;

  assign idx       = 3'(4'd7 - bit_q);
  assign addr_byte = {x_q.addr, ~x_q.wr};
  assign last_bit  = (bit_q == 4'd8);

  always_comb begin
    unique case (slot_q)
      SL_ADDR: drv_bit = last_bit ? 1'b1 : addr_byte[idx];
      SL_WR:   drv_bit = last_bit ? 1'b1 : x_q.wbyte[idx];
      SL_RD1:  drv_bit = last_bit ? !x_q.m16 : 1'b1;  // ack first of two
      default: drv_bit = 1'b1;                         // nack the last byte
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_START: scl_low_o = (ph_q == 2'd3);
      ST_BYTE,
      ST_STOP:  scl_low_o = !ph_q[1];
      default:  scl_low_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= SL_ADDR;
      x_q    <= '0;
      ph_q   <= '0;
      bit_q  <= '0;
      sda_q  <= 1'b0;
      samp_q <= 1'b1;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && st_q == ST_IDLE) begin
        st_q   <= ST_START;
        slot_q <= SL_ADDR;
        x_q    <= xfer_i;
        ph_q   <= '0;
        bit_q  <= '0;
        fail_q <= 1'b0;
        rx_q   <= '0;
        sda_q  <= 1'b0;
      end else if (tick_i && st_q != ST_IDLE) begin
        ph_q <= ph_q + 2'd1;
        unique case (st_q)
          ST_START: begin
            if (ph_q == 2'd0) sda_q <= 1'b1;
            if (ph_q == 2'd3) st_q  <= ST_BYTE;
          end
          ST_BYTE: begin
            if (ph_q == 2'd0) sda_q  <= !drv_bit;
            if (ph_q == 2'd2) samp_q <= sda_i;
            if (ph_q == 2'd3) begin
              if (!last_bit) begin
                bit_q <= bit_q + 4'd1;
                if (slot_q == SL_RD1 || slot_q == SL_RD2) rx_q <= {rx_q[14:0], samp_q};
              end else begin
                bit_q <= '0;
                unique case (slot_q)
                  SL_ADDR: begin
                    if (samp_q) begin
                      fail_q <= 1'b1;
                      st_q   <= ST_STOP;
                    end else begin
                      slot_q <= x_q.wr ? SL_WR : SL_RD1;
                    end
                  end
                  SL_WR: begin
                    fail_q <= samp_q;
                    st_q   <= ST_STOP;
                  end
                  SL_RD1: begin
                    if (x_q.m16) slot_q <= SL_RD2;
                    else         st_q   <= ST_STOP;
                  end
                  default: st_q <= ST_STOP;
                endcase
              end
            end
          end
          ST_STOP: begin
            if (ph_q == 2'd0) sda_q <= 1'b1;
            if (ph_q == 2'd2) sda_q <= 1'b0;
            if (ph_q == 2'd3) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign rdata_o   = rx_q;
  assign sda_low_o = sda_q;
  assign st_o      = st_q;
endmodule

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
module i2c_reg_master
  import i2c_ctl_pkg::*;
#(
  parameter int PRESC_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NBUS-1:0]   sda_i,
  output logic [NBUS-1:0]   scl_oe_o,
  output logic [NBUS-1:0]   sda_oe_o
);
  logic [SET_W-1:0] set_q;
  logic [30:0]      cmd_q;
  logic [1:0]       status_q;
  logic             bus_q;
  logic             enable, go, busy, done, fail, tick, scl_low, sda_low, sda_in;
  logic [15:0]      rx;
  xfer_t            xfer;
  seq_st_e          seq_st;

  assign enable = set_q[SET_EN_BIT];
  assign go     = reg_we_i && (reg_addr_i == 2'd1) && reg_wdata_i[CMD_GO_BIT]
                  && enable && !busy;

  assign xfer.addr  = reg_wdata_i[22:16];
  assign xfer.wr    = reg_wdata_i[CMD_WR_BIT];
  assign xfer.m16   = reg_wdata_i[CMD_M16_BIT];
  assign xfer.wbyte = reg_wdata_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q    <= '0;
      cmd_q    <= '0;
      status_q <= STAT_PEND;
      bus_q    <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == 2'd0) set_q <= reg_wdata_i[SET_W-1:0];
      if (reg_we_i && reg_addr_i == 2'd1) cmd_q <= reg_wdata_i[30:0];
      if (go) begin
        status_q <= STAT_PEND;
        bus_q    <= set_q[SET_BUS_BIT];
      end else if (done) begin
        status_q <= fail ? STAT_FAIL : STAT_OK;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      2'd0:    reg_rdata_o = {{(REG_W-SET_W){1'b0}}, set_q};
      2'd1:    reg_rdata_o = {1'b0, cmd_q};
      2'd2:    reg_rdata_o = {4'b0, status_q, 10'b0, rx};
      default: reg_rdata_o = '0;
    endcase
  end

  i2c_quarter_div #(.PRESC_W(PRESC_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .load_i  (go),
    .presc_i (set_q[PRESC_W-1:0]),
    .tick_o  (tick)
  );

  i2c_bit_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .go_i      (go),
    .xfer_i    (xfer),
    .sda_i     (sda_in),
    .busy_o    (busy),
    .done_o    (done),
    .fail_o    (fail),
    .rdata_o   (rx),
    .scl_low_o (scl_low),
    .sda_low_o (sda_low),
    .st_o      (seq_st)
  );

  i2c_bus_mux #(.NBUS(NBUS)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (bus_q),
    .scl_low_i (scl_low),
    .sda_low_i (sda_low),
    .sda_i     (sda_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .sda_o     (sda_in)
  );
endmodule

// File: rtl/i2c_reg_master_chk.sv
`timescale 1ns/1ps
module i2c_reg_master_chk
  import i2c_ctl_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NBUS-1:0] scl_oe_o,
  input logic [NBUS-1:0] sda_oe_o,
  input logic            busy_i,
  input logic            en_i,
  input logic [1:0]      status_i,
  input seq_st_e         st_i
);
  AST_ONE_BUS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((scl_oe_o[0] | sda_oe_o[0]) && (scl_oe_o[1] | sda_oe_o[1])));  // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (scl_oe_o == '0 && sda_oe_o == '0));  // R10

  AST_SDA_UNDER_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o == '0 && $past(scl_oe_o) == '0 && sda_oe_o != $past(sda_oe_o))
    |-> (($rose(|sda_oe_o) && st_i == ST_START) || ($fell(|sda_oe_o) && st_i == ST_STOP)));  // R10

  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !en_i) |=> !busy_i);  // R3

  AST_PENDING_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> status_i == STAT_PEND);  // R5

  AST_DONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |=> (status_i == STAT_OK || status_i == STAT_FAIL));  // R5
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .busy_i   (busy),
  .en_i     (enable),
  .status_i (status_q),
  .st_i     (seq_st)
);

// File: tb/i2c_reg_master_tb.sv
`timescale 1ns/1ps
module i2c_reg_master_tb;
  localparam logic [6:0] SLV_ADDR = 7'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  sda_in;
  logic [1:0]  scl_oe, sda_oe;

  int vectors = 0;
  int fails = 0;
  int tb_bus = 0;
  logic slv_drv = 1'b0;
  logic nack_data = 1'b0;

  always #4 clk = ~clk;

  assign sda_in[0] = ~(sda_oe[0] | (slv_drv && tb_bus == 0));
  assign sda_in[1] = ~(sda_oe[1] | (slv_drv && tb_bus == 1));

  i2c_reg_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sda_i(sda_in),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural target
  logic [7:0] rxq[$];
  bit         ackq[$];
  logic [7:0] rd_data[2] = '{8'hC3, 8'h5E};
  int starts = 0, stops = 0, last_high = 0, hcnt = 0;
  logic pscl = 1'b1, psda = 1'b1;
  bit active = 0, seen_rise = 0, in_read = 0, addressed = 0, rw = 0, mst_ack = 0;
  int bitn = 0, nbyte = 0;
  logic [7:0] sh = '0, cur = '0;

  always @(negedge clk) begin
    logic scl, sda;
    scl = ~scl_oe[tb_bus];
    sda = ~(sda_oe[tb_bus] | slv_drv);
    if (rst_n) begin
      // per-clock: unselected bus quiet (R2)
      check((scl_oe[1-tb_bus] | sda_oe[1-tb_bus]) == 1'b0, "R2 other bus quiet",
            {30'b0, scl_oe[1-tb_bus], sda_oe[1-tb_bus]}, 0);
    end
    if (scl && !pscl) hcnt = 1;
    else if (scl) hcnt++;
    if (!scl && pscl) last_high = hcnt;

    if (scl && pscl && psda && !sda) begin
      starts++; active = 1; seen_rise = 0; bitn = 0; nbyte = 0;
      in_read = 0; addressed = 0; slv_drv = 0;
    end else if (scl && pscl && !psda && sda) begin
      stops++; active = 0; slv_drv = 0;
    end else if (active) begin
      if (scl && !pscl) begin
        seen_rise = 1;
        if (bitn < 8 && !in_read) sh = {sh[6:0], sda};
        if (bitn == 8 && in_read) begin mst_ack = !sda; ackq.push_back(mst_ack); end
      end
      if (!scl && pscl && seen_rise) begin
        if (bitn < 7) begin
          bitn++;
          slv_drv = in_read ? ~cur[7-bitn] : 1'b0;
        end else if (bitn == 7) begin
          bitn = 8;
          if (in_read) slv_drv = 0;
          else begin
            rxq.push_back(sh);
            if (nbyte == 0) begin
              addressed = (sh[7:1] == SLV_ADDR); rw = sh[0]; slv_drv = addressed;
            end else slv_drv = addressed && !nack_data;
          end
        end else begin
          bitn = 0; nbyte++;
          if (in_read && !mst_ack) slv_drv = 0;
          else if (nbyte <= 2 && (in_read || (nbyte == 1 && addressed && rw))) begin
            in_read = 1; cur = rd_data[nbyte-1]; slv_drv = ~cur[7];
          end else slv_drv = 0;
        end
      end
    end
    pscl = scl; psda = sda;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] rep);
    rd_reg(2, rep);
    for (int i = 0; i < 5000 && rep[27:26] == 2'b00; i++) rd_reg(2, rep);
  endtask

  task automatic clear_log();
    rxq.delete(); ackq.delete();
  endtask

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, saved;
    int s0, p0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    rd_reg(2, r); check(r == 0, "R5 reply reset", r, 0);
    rd_reg(0, r); check(r == 0, "R1 settings reset", r, 0);
    check({scl_oe, sda_oe} == 0, "R10 lines released after reset", {scl_oe, sda_oe}, 0);

    wr_reg(0, 32'h0000_1810 & 32'h0000_0FFF | 32'h0000_1000);
    rd_reg(0, r); check(r == 32'h0000_1810, "R1 settings readback", r, 32'h1810);
    wr_reg(0, 32'hFFFF_E810);
    rd_reg(0, r); check(r == 32'h0000_0810, "R1 settings upper bits zero", r, 32'h0810);

    // R6 write
    clear_log(); s0 = starts; p0 = stops;
    wr_reg(1, 32'h80AA_005A);
    rd_reg(2, r); check(r[27:26] == 2'b00, "R5 pending after accept", r[27:26], 0);
    rd_reg(1, r); check(r == 32'h00AA_005A, "R4 strobe self-clears", r, 32'h00AA005A);
    wait_done(r);
    check(r[27:26] == 2'b01, "R5 write success", r[27:26], 1);
    check(rxq.size() == 2 && rxq[0] == 8'h54, "R6 address byte", rxq.size() ? rxq[0] : 0, 8'h54);
    check(rxq.size() == 2 && rxq[1] == 8'h5A, "R6 data byte", rxq.size() > 1 ? rxq[1] : 0, 8'h5A);
    check(starts == s0 + 1 && stops == p0 + 1, "R6 one start and stop", stops - p0, 1);
    check(last_high == 8, "R1 SCL high time P/2", last_high, 8);

    // R7 single-byte read
    clear_log();
    wr_reg(1, 32'h802A_0000);
    wait_done(r);
    check(r[27:26] == 2'b01, "R7 read success", r[27:26], 1);
    check(r[15:0] == 16'h00C3, "R7 read byte low", r[15:0], 16'h00C3);
    check(rxq.size() == 1 && rxq[0] == 8'h55, "R7 address with read bit", rxq.size() ? rxq[0] : 0, 8'h55);
    check(ackq.size() == 1 && ackq[0] == 0, "R7 last byte nacked", ackq.size(), 1);

    // R8 two-byte read
    clear_log();
    wr_reg(1, 32'h822A_0000);
    wait_done(r);
    check(r[27:26] == 2'b01, "R8 read16 success", r[27:26], 1);
    check(r[15:0] == 16'hC35E, "R8 byte order", r[15:0], 16'hC35E);
    check(ackq.size() == 2 && ackq[0] == 1 && ackq[1] == 0, "R8 ack then nack",
          ackq.size() == 2 ? {ackq[0], ackq[1]} : 32'hFF, 2'b10);

    // R9 address nack
    clear_log(); p0 = stops;
    wr_reg(1, 32'h80AB_0011);
    wait_done(r);
    check(r[27:26] == 2'b11, "R9 address nack fails", r[27:26], 3);
    check(stops == p0 + 1, "R9 stop after address nack", stops - p0, 1);
    check(rxq.size() == 1, "R9 no data byte sent", rxq.size(), 1);

    // R9 data nack
    nack_data = 1; p0 = stops;
    wr_reg(1, 32'h80AA_0033);
    wait_done(r);
    check(r[27:26] == 2'b11, "R9 data nack fails", r[27:26], 3);
    check(stops == p0 + 1, "R9 stop after data nack", stops - p0, 1);
    nack_data = 0;

    // R2 second bus
    wr_reg(0, 32'h0000_0C10);
    tb_bus = 1; clear_log();
    wr_reg(1, 32'h80AA_00A5);
    wait_done(r);
    check(r[27:26] == 2'b01, "R2 bus1 success", r[27:26], 1);
    check(rxq.size() == 2 && rxq[1] == 8'hA5, "R2 bus1 data", rxq.size() > 1 ? rxq[1] : 0, 8'hA5);

    // R3 disabled strobe ignored
    wr_reg(0, 32'h0000_0010);
    rd_reg(2, saved); s0 = starts;
    wr_reg(1, 32'h80AA_0077);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check({scl_oe, sda_oe} == 0, "R3 no bus activity when disabled", {scl_oe, sda_oe}, 0);
    end
    rd_reg(2, r); check(r == saved, "R3 reply unchanged", r, saved);
    check(starts == s0, "R3 no start", starts - s0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule